// File: doc/BRIEF.md
# Priority Task Dispatcher with Hardware Delays

This block chooses which task should run next. It watches a set of external event lines and a bank of per-task countdown timers. Each event line maps to one task, and the line's position is both its priority and the number of the task it wakes. A rising edge on a line, or a countdown that runs out, marks the task as pending. The highest-numbered pending task is offered on a valid/task-number output. The offer is made only when that task outranks the task that is running now.

The block keeps a free-running time counter that advances by one tick every `TICK_DIV` clocks. Software loads a countdown for a task through a small write port, as a number of ticks. The hardware counts the ticks down and raises the task by itself when the count runs out, so no kernel routine has to walk a delay list at each scheduling point. When the consumer accepts an offer, the task's pending mark clears and the task becomes the running level. A completion pulse drops the running level back to idle.

Top module: `tdisp_core`

## Requirements
- R1: While reset is asserted and right after it, no task is offered (`dsp_valid` low), the running level is idle and `sys_time` is 0.
- R2: Each event line passes through two synchroniser flops. A low-to-high change on line i makes task i pending, so `dsp_valid` rises on the third rising clock edge after the line goes high. A line held high produces only one event.
- R3: When several tasks are pending, `dsp_task` shows the highest index among them.
- R4: The offer is made only when (offered index + 1) is strictly greater than the running level, where 0 means idle and level k means task k-1 is running. A lower pending task waits until `task_done`. A higher one is offered at once (preemption).
- R5: An accepting cycle (`dsp_valid` and `dsp_ack` high at a clock edge) clears the pending mark of the offered task and sets the running level to that task. `task_done` alone sets the running level to idle. If both are high in the same cycle, the accept takes effect.
- R6: `sys_time` increases by exactly one every `TICK_DIV` clock cycles.
- R7: A write of N > 0 to task `dly_sel` (the index in `dly_sel`, the count in `dly_ticks`) makes that task pending on the Nth tick after the write, which is the edge at which `sys_time` reaches its value at the write plus N.
- R8: A write of 0 stops a running countdown, and that task is never raised by it.
- R9: A new write to a task whose countdown is running replaces the remaining count, and the count restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | N | Asynchronous event lines, bit i wakes task i |
| dly_we | input | 1 | Countdown write strobe |
| dly_sel | input | $clog2(N) | Task whose countdown is written |
| dly_ticks | input | DW | Countdown in ticks, 0 stops it |
| dsp_ack | input | 1 | Consumer accepts the current offer |
| task_done | input | 1 | Running task has finished, level goes idle |
| dsp_valid | output | 1 | A task is offered for dispatch |
| dsp_task | output | $clog2(N) | Number of the offered task |
| sys_time | output | TW | Tick count since reset |

## Verification
The bench builds the block with six tasks, an 8-bit countdown and a 16-bit time counter. It sets `TICK_DIV` to 3, which is not a power of two, so each prescaler wrap is tested at a non-aligned boundary. With ticks only three clocks apart, countdowns of several ticks run out within a few dozen cycles. That leaves time to check the tick just before an expiry, the expiry itself, cancellation and reload. All tasks 0 through 5 are reachable, so the highest and lowest priorities are both exercised, including preemption by the top task.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
   // running level that means no task is active
   localparam int unsigned LEVEL_IDLE = 0;

   // width needed to hold a running level for n tasks (0 .. n)
   function automatic int unsigned level_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tdisp_edge.sv
module tdisp_edge #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_in,
   output logic [N-1:0] rise
);
   for (genvar g = 0; g < N; g++) begin : g_line
      // [0] first sync flop, [1] second sync flop, [2] previous synced value
      logic [2:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[1:0], sig_in[g]};
      end
      assign rise[g] = sh_q[1] & ~sh_q[2];
   end
endmodule

// File: rtl/tdisp_timebase.sv
module tdisp_timebase #(
   parameter int unsigned TICK_DIV = 4,
   parameter int unsigned TW       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          tick,
   output logic [TW-1:0] sys_time
);
   localparam int unsigned DVW = $clog2(TICK_DIV);

   logic [DVW-1:0] div_q;

   assign tick = (div_q == DVW'(TICK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         sys_time <= '0;
      end else if (tick) begin
         div_q    <= '0;
         sys_time <= sys_time + TW'(1);
      end else begin
         div_q    <= div_q + DVW'(1);
      end
   end
endmodule

// File: rtl/tdisp_delays.sv
module tdisp_delays #(
   parameter int unsigned N  = 6,
   parameter int unsigned DW = 8,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          we,
   input  logic [IW-1:0] sel,
   input  logic [DW-1:0] ticks,
   output logic [N-1:0]  expire
);
   for (genvar g = 0; g < N; g++) begin : g_task
      logic [DW-1:0] cnt_q;
      logic          hit;

      assign hit = we && (sel == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt_q <= '0;
         else if (hit)                   cnt_q <= ticks;
         else if (tick && cnt_q != '0)   cnt_q <= cnt_q - DW'(1);
      end

      // a write in the same cycle replaces the count and suppresses expiry
      assign expire[g] = tick && (cnt_q == DW'(1)) && !hit;
   end
endmodule

// File: rtl/tdisp_pick.sv
module tdisp_pick #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  pend,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (pend[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tdisp_core.sv
module tdisp_core #(
   parameter int unsigned N        = 6,
   parameter int unsigned TICK_DIV = 4,
   parameter int unsigned DW       = 8,
   parameter int unsigned TW       = 16,
   localparam int unsigned IW      = $clog2(N),
   localparam int unsigned LW      = tdisp_pkg::level_width(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  sig_in,
   input  logic          dly_we,
   input  logic [IW-1:0] dly_sel,
   input  logic [DW-1:0] dly_ticks,
   input  logic          dsp_ack,
   input  logic          task_done,
   output logic          dsp_valid,
   output logic [IW-1:0] dsp_task,
   output logic [TW-1:0] sys_time
);
   if (N < 2) begin : g_bad_n
      $error("tdisp_core: N must be at least 2");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("tdisp_core: TICK_DIV must be at least 2");
   end
   if (DW < 1 || TW < 2) begin : g_bad_w
      $error("tdisp_core: DW and TW too small");
   end

   logic [N-1:0]  rise;
   logic [N-1:0]  expire;
   logic          tick;
   logic          win_any;
   logic [IW-1:0] win_idx;
   logic [N-1:0]  pend_q;
   logic [LW-1:0] level_q;
   logic [LW-1:0] win_level;
   logic          take;
   logic [N-1:0]  clr_mask;

   tdisp_edge #(.N(N)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (sig_in),
      .rise   (rise)
   );

   tdisp_timebase #(.TICK_DIV(TICK_DIV), .TW(TW)) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sys_time (sys_time)
   );

   tdisp_delays #(.N(N), .DW(DW), .IW(IW)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .we     (dly_we),
      .sel    (dly_sel),
      .ticks  (dly_ticks),
      .expire (expire)
   );

   tdisp_pick #(.N(N), .IW(IW)) u_pick (
      .pend (pend_q),
      .any  (win_any),
      .idx  (win_idx)
   );

   assign win_level = LW'(win_idx) + LW'(1);
   assign dsp_valid = win_any && (win_level > level_q);
   assign dsp_task  = win_idx;
   assign take      = dsp_valid && dsp_ack;
   assign clr_mask  = take ? (N'(1) << win_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         level_q <= LW'(tdisp_pkg::LEVEL_IDLE);
      end else begin
         // new events win over a clear of the same bit
         pend_q <= (pend_q & ~clr_mask) | rise | expire;
         if (take)           level_q <= win_level;
         else if (task_done) level_q <= LW'(tdisp_pkg::LEVEL_IDLE);
      end
   end
endmodule

// File: rtl/tdisp_chk.sv
module tdisp_chk #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = 3,
   parameter int unsigned LW = 3,
   parameter int unsigned TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  pend,
   input logic [LW-1:0] level,
   input logic          dsp_valid,
   input logic [IW-1:0] dsp_task,
   input logic          dsp_ack,
   input logic [TW-1:0] sys_time
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!dsp_valid && level == '0 && sys_time == '0));

   a_r2_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |-> pend[dsp_task]);

   a_r3_no_higher_pending: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |-> (((pend >> dsp_task) >> 1) == '0));

   a_r4_outranks_running: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |-> ((LW'(dsp_task) + LW'(1)) > level));

   a_r5_accept_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && dsp_ack) |=> (level == $past(LW'(dsp_task) + LW'(1))));

   a_r6_time_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sys_time == $past(sys_time) || sys_time == $past(sys_time) + TW'(1)));
endmodule

bind tdisp_core tdisp_chk #(.N(N), .IW(IW), .LW(LW), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pend      (pend_q),
   .level     (level_q),
   .dsp_valid (dsp_valid),
   .dsp_task  (dsp_task),
   .dsp_ack   (dsp_ack),
   .sys_time  (sys_time)
);

// File: tb/tb_tdisp_core.sv
`timescale 1ns/1ps
module tb_tdisp_core;
   localparam int unsigned N   = 6;
   localparam int unsigned DIV = 3;
   localparam int unsigned DW  = 8;
   localparam int unsigned TW  = 16;
   localparam int unsigned IW  = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  sig_in = '0;
   logic          dly_we = 1'b0;
   logic [IW-1:0] dly_sel = '0;
   logic [DW-1:0] dly_ticks = '0;
   logic          dsp_ack = 1'b0;
   logic          task_done = 1'b0;
   logic          dsp_valid;
   logic [IW-1:0] dsp_task;
   logic [TW-1:0] sys_time;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tdisp_core #(.N(N), .TICK_DIV(DIV), .DW(DW), .TW(TW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_in    (sig_in),
      .dly_we    (dly_we),
      .dly_sel   (dly_sel),
      .dly_ticks (dly_ticks),
      .dsp_ack   (dsp_ack),
      .task_done (task_done),
      .dsp_valid (dsp_valid),
      .dsp_task  (dsp_task),
      .sys_time  (sys_time)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_offer(input string req, input int task_no);
      chk(dsp_valid == 1'b1, req, int'(dsp_valid), 1);
      chk(int'(dsp_task) == task_no, req, int'(dsp_task), task_no);
   endtask

   task automatic accept();
      dsp_ack = 1'b1;
      cyc(1);
      dsp_ack = 1'b0;
   endtask

   task automatic finish_task();
      task_done = 1'b1;
      cyc(1);
      task_done = 1'b0;
   endtask

   task automatic write_delay(input int t, input int n);
      dly_we    = 1'b1;
      dly_sel   = IW'(t);
      dly_ticks = DW'(n);
      cyc(1);
      dly_we    = 1'b0;
   endtask

   // wait until just after a tick edge, return the new time
   task automatic sync_to_tick(output int t);
      int start = int'(sys_time);
      for (int i = 0; i < 4 * DIV; i++) begin
         cyc(1);
         if (int'(sys_time) != start) break;
      end
      t = int'(sys_time);
   endtask

   task automatic wait_time(input int target);
      for (int i = 0; i < 64 * DIV; i++) begin
         if (int'(sys_time) == target) break;
         cyc(1);
      end
   endtask

   task automatic t_reset();
      chk(dsp_valid == 1'b0, "R1 valid", int'(dsp_valid), 0);
      chk(sys_time == '0, "R1 time", int'(sys_time), 0);
   endtask

   task automatic t_edge();
      sig_in[2] = 1'b1;
      cyc(2);
      chk(dsp_valid == 1'b0, "R2 early", int'(dsp_valid), 0);
      cyc(1);
      expect_offer("R2 latency", 2);
      accept();
      chk(dsp_valid == 1'b0, "R5 cleared", int'(dsp_valid), 0);
      cyc(10);
      chk(dsp_valid == 1'b0, "R2 held line", int'(dsp_valid), 0);
      sig_in[2] = 1'b0;
      finish_task();
      cyc(4);
   endtask

   task automatic t_priority();
      sig_in[1] = 1'b1;
      sig_in[4] = 1'b1;
      cyc(3);
      expect_offer("R3 highest", 4);
      accept();
      chk(dsp_valid == 1'b0, "R4 lower held", int'(dsp_valid), 0);
      cyc(3);
      chk(dsp_valid == 1'b0, "R4 still held", int'(dsp_valid), 0);
      finish_task();
      expect_offer("R4 after done", 1);
      accept();
      finish_task();
      sig_in = '0;
      cyc(4);
      chk(dsp_valid == 1'b0, "R5 nothing left", int'(dsp_valid), 0);
   endtask

   task automatic t_preempt();
      sig_in[0] = 1'b1;
      cyc(3);
      expect_offer("R4 lowest idle", 0);
      accept();
      sig_in[5] = 1'b1;
      cyc(3);
      expect_offer("R4 preempt", 5);
      accept();
      chk(dsp_valid == 1'b0, "R5 top running", int'(dsp_valid), 0);
      finish_task();
      sig_in = '0;
      cyc(4);
   endtask

   task automatic t_time();
      int t0 = int'(sys_time);
      cyc(5 * DIV);
      chk(int'(sys_time) == t0 + 5, "R6 rate", int'(sys_time), t0 + 5);
      cyc(7 * DIV);
      chk(int'(sys_time) == t0 + 12, "R6 rate long", int'(sys_time), t0 + 12);
   endtask

   task automatic t_delay();
      int t0;
      sync_to_tick(t0);
      write_delay(3, 4);
      wait_time(t0 + 3);
      chk(dsp_valid == 1'b0, "R7 before expiry", int'(dsp_valid), 0);
      wait_time(t0 + 4);
      expect_offer("R7 expiry", 3);
      accept();
      finish_task();
      wait_time(t0 + 8);
      chk(dsp_valid == 1'b0, "R7 one shot", int'(dsp_valid), 0);
   endtask

   task automatic t_cancel();
      int t0;
      sync_to_tick(t0);
      write_delay(4, 5);
      wait_time(t0 + 2);
      write_delay(4, 0);
      wait_time(t0 + 8);
      chk(dsp_valid == 1'b0, "R8 cancelled", int'(dsp_valid), 0);
   endtask

   task automatic t_restart();
      int t0;
      int t1;
      sync_to_tick(t0);
      write_delay(5, 6);
      sync_to_tick(t1);
      write_delay(5, 2);
      wait_time(t1 + 1);
      chk(dsp_valid == 1'b0, "R9 not yet", int'(dsp_valid), 0);
      wait_time(t1 + 2);
      expect_offer("R9 reload", 5);
      accept();
      finish_task();
      wait_time(t0 + 8);
      chk(dsp_valid == 1'b0, "R9 old count gone", int'(dsp_valid), 0);
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_edge();
      t_priority();
      t_preempt();
      t_time();
      t_delay();
      t_cancel();
      t_restart();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule